// File: doc/BRIEF.md
# Descriptor-Chained Copy Engine

This block is one direction of a memory-to-memory copy channel. It sits between a host address space and a local on-chip memory. Software first builds a table of descriptors in host memory. It then loads the table's start address and starts the engine with a single write of the descriptor count. From then on the engine needs no register access until the chain is finished. It reads each descriptor over the host-side master, copies the block that descriptor names, and moves on to the next entry.

Each descriptor occupies four consecutive 32-bit words. Two control bits in each descriptor decide how the engine reports back to software: it can raise an interrupt request, write a completion word back into the descriptor, do both, or do neither. A parameter fixes the copy direction, so that a read engine and a write engine are two instances of the same module. All addresses and sizes are whole 32-bit words, and data moves one word per beat.

Top module: `chain_dma`

## Requirements
- R1: After reset the status register (offset 2) reads zero, `irq` is low, and neither master issues a read or a write.
- R2: A write to offset 0 stores the table start address. A write of a nonzero value to offset 1 stores the descriptor count and starts the engine. Busy (status bit 0) reads 1 from the next cycle on. Offsets 0 and 1 read back the stored values.
- R3: Descriptor i is fetched from host address base + 16*i as four words, in this order: size in words, source address, destination address, control. Exactly `count` descriptors are processed.
- R4: Each descriptor copies `size` words, in ascending address order, from the source to the destination. With HOST_TO_LOCAL=1 the source is on the host master and the destination is on the local master; with 0 the two are swapped. Only one master request is active in any cycle.
- R5: While a master's waitrequest is high, the pending request, its address and its write data stay unchanged. No beat is lost or repeated.
- R6: If control bit 1 is set, the engine writes the word 32'h8000_0000 | i to host address base + 16*i + 12 after the descriptor's data has moved. If the bit is clear, that word is not written.
- R7: If control bit 0 is set, `irq` goes high once that descriptor completes. It stays high until a write to offset 2 with bit 2 set. Status bit 2 mirrors `irq`.
- R8: Status bit 1 is a sticky done flag. It is set when the last descriptor completes and cleared by a write to offset 2 with bit 1 set. Status bits 31:16 give the index of the current or last descriptor.
- R9: A count of zero sets done at once, never sets busy, and causes no memory traffic.
- R10: While busy, writes to offsets 0 and 1 are ignored.
- R11: A descriptor of size zero moves no data but still completes, including its write-back and interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 2 | Register word select: 0 base, 1 count/start, 2 status |
| csr_write | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational from csr_addr |
| h_addr | output | AW | Host master byte address |
| h_read | output | 1 | Host master read request |
| h_write | output | 1 | Host master write request |
| h_wdata | output | 32 | Host master write data |
| h_rdata | input | 32 | Host master read data |
| h_rdv | input | 1 | Host master read data valid |
| h_wait | input | 1 | Host master waitrequest |
| l_addr | output | AW | Local master byte address |
| l_read | output | 1 | Local master read request |
| l_write | output | 1 | Local master write request |
| l_wdata | output | 32 | Local master write data |
| l_rdata | input | 32 | Local master read data |
| l_rdv | input | 1 | Local master read data valid |
| l_wait | input | 1 | Local master waitrequest |
| irq | output | 1 | Interrupt request, level, sticky |

## Verification
The assertions check the cycle-level rules on every cycle. A stalled request must hold its address and data, and only one master may be active at a time. The engine must stay quiet when idle, `irq` and done must stay set until cleared, a zero count must finish without starting, and writes must not disturb the base and count while a chain runs. Whether the right words reach the right addresses shows only in the bench's scenarios. Those scenarios run chains of varied length and size under random stalls, then compare memory contents, the write-back words, the untouched words past each block, and the status index.

// File: rtl/chain_dma.sv
module chain_dma #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter bit HOST_TO_LOCAL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    csr_addr,
  input  logic          csr_write,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  output logic [AW-1:0] h_addr,
  output logic          h_read,
  output logic          h_write,
  output logic [31:0]   h_wdata,
  input  logic [31:0]   h_rdata,
  input  logic          h_rdv,
  input  logic          h_wait,
  output logic [AW-1:0] l_addr,
  output logic          l_read,
  output logic          l_write,
  output logic [31:0]   l_wdata,
  input  logic [31:0]   l_rdata,
  input  logic          l_rdv,
  input  logic          l_wait,
  output logic          irq
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_FWAIT, S_RD, S_RWAIT, S_WR, S_STAT, S_FIN} st_t;

  st_t st;
  logic [AW-1:0] base, dptr, src, dst;
  logic [CW-1:0] cnt, idx;
  logic [1:0]    k, ctl;
  logic [31:0]   size, buf_q;
  logic          done, irq_q;

  wire busy      = (st != S_IDLE);
  wire clr_wr    = csr_write && csr_addr == 2'd2;
  wire last      = (idx == cnt - CW'(1));
  wire src_wait  = HOST_TO_LOCAL ? h_wait : l_wait;
  wire dst_wait  = HOST_TO_LOCAL ? l_wait : h_wait;
  wire src_rdv   = HOST_TO_LOCAL ? h_rdv : l_rdv;
  wire [31:0] src_data = HOST_TO_LOCAL ? h_rdata : l_rdata;
  wire [31:0] wb_word  = 32'h8000_0000 | 32'(idx);

  assign h_read  = st == S_FETCH || (st == S_RD && HOST_TO_LOCAL);
  assign l_read  = st == S_RD && !HOST_TO_LOCAL;
  assign h_write = st == S_STAT || (st == S_WR && !HOST_TO_LOCAL);
  assign l_write = st == S_WR && HOST_TO_LOCAL;
  assign h_addr  = st == S_FETCH ? dptr + AW'({k, 2'b00}) :
                   st == S_STAT  ? dptr + AW'(12) :
                   st == S_RD    ? src : dst;
  assign l_addr  = st == S_RD ? src : dst;
  assign h_wdata = st == S_STAT ? wb_word : buf_q;
  assign l_wdata = buf_q;
  assign irq     = irq_q;

  always_comb begin
    case (csr_addr)
      2'd0:    csr_rdata = 32'(base);
      2'd1:    csr_rdata = 32'(cnt);
      2'd2:    csr_rdata = {16'(idx), 13'd0, irq_q, done, busy};
      default: csr_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; base <= '0; dptr <= '0; src <= '0; dst <= '0;
      cnt <= '0; idx <= '0; k <= '0; ctl <= '0; size <= '0; buf_q <= '0;
      done <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (clr_wr && csr_wdata[1]) done <= 1'b0;
      if (clr_wr && csr_wdata[2]) irq_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (csr_write && csr_addr == 2'd0) base <= csr_wdata[AW-1:0];
          if (csr_write && csr_addr == 2'd1) begin
            cnt <= csr_wdata[CW-1:0];
            if (csr_wdata[CW-1:0] == '0) done <= 1'b1;
            else begin
              idx <= '0; dptr <= base; k <= '0; st <= S_FETCH;
            end
          end
        end
        S_FETCH: if (!h_wait) st <= S_FWAIT;
        S_FWAIT: if (h_rdv) begin
          case (k)
            2'd0: size <= h_rdata;
            2'd1: src  <= h_rdata[AW-1:0];
            2'd2: dst  <= h_rdata[AW-1:0];
            default: ctl <= h_rdata[1:0];
          endcase
          if (k == 2'd3) st <= (size == 0) ? (h_rdata[1] ? S_STAT : S_FIN) : S_RD;
          else begin
            k <= k + 2'd1; st <= S_FETCH;
          end
        end
        S_RD: if (!src_wait) st <= S_RWAIT;
        S_RWAIT: if (src_rdv) begin
          buf_q <= src_data; st <= S_WR;
        end
        S_WR: if (!dst_wait) begin
          src <= src + AW'(4); dst <= dst + AW'(4); size <= size - 32'd1;
          st <= (size == 32'd1) ? (ctl[1] ? S_STAT : S_FIN) : S_RD;
        end
        S_STAT: if (!h_wait) st <= S_FIN;
        default: begin
          if (ctl[0]) irq_q <= 1'b1;
          if (last) begin
            done <= 1'b1; st <= S_IDLE;
          end else begin
            idx <= idx + CW'(1); dptr <= dptr + AW'(16); k <= '0; st <= S_FETCH;
          end
        end
      endcase
    end
  end

  assert_hold_host_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_read && h_wait) |=> (h_read && $stable(h_addr)));
  assert_hold_host_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_write && h_wait) |=> (h_write && $stable(h_addr) && $stable(h_wdata)));
  assert_hold_loc_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (l_read && l_wait) |=> (l_read && $stable(l_addr)));
  assert_hold_loc_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (l_write && l_wait) |=> (l_write && $stable(l_addr) && $stable(l_wdata)));
  assert_one_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({h_read, h_write, l_read, l_write}) <= 1);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rdata[0] && csr_addr == 2'd2 |-> !(h_read || h_write || l_read || l_write));
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(clr_wr && csr_wdata[2])) |=> irq);
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(clr_wr && csr_wdata[1])) |=> done);
  assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && csr_write && csr_addr == 2'd1 && csr_wdata[CW-1:0] == '0) |=> (!busy && done));
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && csr_write && csr_addr != 2'd2) |=> ($stable(base) && $stable(cnt)));
endmodule

// File: tb/chain_dma_bench.sv
module chain_dma_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] csr_addr = 2'd0;
  logic csr_write = 1'b0;
  logic [31:0] csr_wdata = 32'd0;
  logic [31:0] csr_rdata;
  logic [31:0] h_addr, l_addr, h_wdata, l_wdata;
  logic h_read, h_write, l_read, l_write, irq;
  logic [31:0] h_rdata = 32'd0, l_rdata = 32'd0;
  logic h_rdv = 1'b0, l_rdv = 1'b0;
  logic stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic pk_we = 1'b0, pk_loc = 1'b0;
  logic [9:0] pk_a = 10'd0;
  logic [31:0] pk_d = 32'd0;
  logic [31:0] hmem [0:1023];
  logic [31:0] lmem [0:1023];
  int traffic = 0;
  int checks = 0, errors = 0;

  wire h_wait = stall & lfsr[0];
  wire l_wait = stall & lfsr[3];

  always #4 clk = ~clk;

  chain_dma u_chain_dma (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_write(csr_write),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .h_addr(h_addr), .h_read(h_read), .h_write(h_write), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_rdv(h_rdv), .h_wait(h_wait),
    .l_addr(l_addr), .l_read(l_read), .l_write(l_write), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rdv(l_rdv), .l_wait(l_wait), .irq(irq));

  always @(posedge clk) begin
    h_rdv <= 1'b0;
    l_rdv <= 1'b0;
    if (h_read && !h_wait) begin h_rdv <= 1'b1; h_rdata <= hmem[h_addr[11:2]]; end
    if (h_write && !h_wait) hmem[h_addr[11:2]] <= h_wdata;
    if (l_read && !l_wait) begin l_rdv <= 1'b1; l_rdata <= lmem[l_addr[11:2]]; end
    if (l_write && !l_wait) lmem[l_addr[11:2]] <= l_wdata;
    if (pk_we) begin
      if (pk_loc) lmem[pk_a] <= pk_d;
      else hmem[pk_a] <= pk_d;
    end
    if (((h_read || h_write) && !h_wait) || ((l_read || l_write) && !l_wait)) traffic <= traffic + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // count, base size, control bits, stall enable
  localparam logic [31:0] VEC [0:5] = '{
    {8'd1, 8'd4, 8'd3, 8'd0},
    {8'd3, 8'd2, 8'd1, 8'd1},
    {8'd4, 8'd5, 8'd2, 8'd1},
    {8'd2, 8'd0, 8'd3, 8'd0},
    {8'd5, 8'd1, 8'd0, 8'd1},
    {8'd2, 8'd10, 8'd3, 8'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input bit loc, input int word, input logic [31:0] d);
    @(negedge clk);
    pk_we = 1'b1; pk_loc = loc; pk_a = word[9:0]; pk_d = d;
    @(negedge clk);
    pk_we = 1'b0;
  endtask

  task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_write = 1'b1;
    @(negedge clk);
    csr_write = 1'b0;
  endtask

  task automatic csr_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 20000; n++) begin
      csr_rd(2'd2, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [31:0] pat(input int v, input int i, input int j);
    return 32'hA000_0000 | (v << 16) | (i << 8) | j;
  endfunction

  function automatic logic [31:0] sent(input int v, input int i, input int j);
    return 32'h5E00_0000 | (v << 16) | (i << 8) | j;
  endfunction

  task automatic setup_desc(input int v, input int base, input int i, input int sz, input int ctl);
    poke(1'b0, base / 4 + 4 * i, sz);
    poke(1'b0, base / 4 + 4 * i + 1, 32'h400 + i * 64);
    poke(1'b0, base / 4 + 4 * i + 2, 32'h200 + i * 64);
    poke(1'b0, base / 4 + 4 * i + 3, ctl);
    for (int j = 0; j < 16; j++) begin
      poke(1'b0, 'h100 + i * 16 + j, pat(v, i, j));
      poke(1'b1, 'h80 + i * 16 + j, sent(v, i, j));
    end
  endtask

  initial begin
    logic [31:0] s;
    int cnt, sz0, ctl, base, t0;
    repeat (5) @(negedge clk);
    csr_rd(2'd2, s);
    chk("R1 reset status", s, 32'd0);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    chk("R1 reset requests", {28'd0, h_read, h_write, l_read, l_write}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < 6; v++) begin
      cnt = VEC[v][31:24]; sz0 = VEC[v][23:16]; ctl = VEC[v][15:8];
      stall = VEC[v][0];
      base = v * 'h80;
      for (int i = 0; i <= cnt; i++) setup_desc(v, base, i, sz0 + i, ctl);
      csr_wr(2'd2, 32'd6);
      csr_wr(2'd0, base);
      csr_wr(2'd1, cnt);
      csr_rd(2'd2, s);
      chk("R2 busy after start", {31'd0, s[0]}, 32'd1);
      wait_idle();
      csr_rd(2'd2, s);
      chk("R8 done set", {31'd0, s[1]}, 32'd1);
      chk("R8 last index", {16'd0, s[31:16]}, cnt - 1);
      chk("R7 irq per control bit 0", {31'd0, irq}, ctl & 1);
      chk("R7 status irq bit", {31'd0, s[2]}, ctl & 1);
      for (int i = 0; i < cnt; i++) begin
        for (int j = 0; j < sz0 + i; j++)
          chk("R4 copied word", lmem['h80 + i * 16 + j], pat(v, i, j));
        chk("R11 R4 no word past block", lmem['h80 + i * 16 + sz0 + i], sent(v, i, sz0 + i));
        chk("R6 write-back word", hmem[base / 4 + 4 * i + 3],
            (ctl & 2) ? (32'h8000_0000 | i) : ctl);
      end
      chk("R3 descriptor past count untouched", lmem['h80 + cnt * 16], sent(v, cnt, 0));
    end

    csr_wr(2'd2, 32'd2);
    csr_rd(2'd2, s);
    chk("R8 done cleared by write 1", {31'd0, s[1]}, 32'd0);
    chk("R7 irq kept when only done cleared", {31'd0, irq}, 32'd1);
    csr_wr(2'd2, 32'd4);
    chk("R7 irq cleared by write 1", {31'd0, irq}, 32'd0);

    stall = 1'b0;
    t0 = traffic;
    csr_wr(2'd1, 32'd0);
    csr_rd(2'd2, s);
    chk("R9 zero count done", {30'd0, s[1:0]}, 32'd2);
    repeat (3) @(negedge clk);
    chk("R9 zero count no traffic", traffic - t0, 32'd0);

    stall = 1'b1;
    setup_desc(7, 'h380, 0, 8, 0);
    setup_desc(7, 'h380, 1, 4, 0);
    csr_wr(2'd2, 32'd6);
    csr_wr(2'd0, 32'h380);
    csr_rd(2'd0, s);
    chk("R2 base readback", s, 32'h380);
    csr_wr(2'd1, 32'd1);
    csr_wr(2'd1, 32'd2);
    csr_wr(2'd0, 32'd0);
    wait_idle();
    csr_rd(2'd1, s);
    chk("R10 count unchanged", s, 32'd1);
    csr_rd(2'd0, s);
    chk("R10 base unchanged", s, 32'h380);
    csr_rd(2'd2, s);
    chk("R10 index stays 0", {16'd0, s[31:16]}, 32'd0);
    chk("R10 second block untouched", lmem['h90], sent(7, 1, 0));
    chk("R5 last beat under stalls", lmem['h87], pat(7, 0, 7));
    chk("R5 no extra beat under stalls", lmem['h88], sent(7, 0, 8));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule